// File: doc/BRIEF.md
# Nine-Bit Capable Serial Transmitter

This block serialises one byte per load strobe onto a single output line. Three of its four modes send an asynchronous frame. Each such frame is a low start bit, then eight data bits with the least significant bit first, then an optional ninth bit whose value software supplies, then one high stop bit. The fourth mode turns the block into a synchronous shift-register output. In that mode eight data bits leave at a fixed rate of one twelfth of the system clock, together with a shift clock for the receiving device.

The bit rate comes from one of two places. The fixed-rate modes count system clocks inside the block. The variable-rate modes advance one bit per pulse of an external baud tick, so a divider outside the block sets their rate. A transmit-complete flag is raised once per frame. In the asynchronous modes it rises at the start of the stop bit, which lets software prepare the next byte while the stop bit is still on the line. In the synchronous mode it rises at the end of the eighth bit. The flag stays set until software clears it. The mode, the double-rate select, the data byte and the ninth bit are all captured when a load is accepted. A load strobe that arrives while a frame is in progress is ignored.

Top module: `ser9_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd_o` and `sclk_o` are high. `done_o` is low after reset.
- R2: In the asynchronous modes (`mode_i` = 1, 2 or 3), `txd_o` goes low for the start bit in the cycle after the accepted load. It then carries `data_i` least significant bit first and ends with one high stop bit.
- R3: In modes 1 and 3, each bit lasts from one `baud_tick_i` pulse to the next, and the first bit ends at the first pulse after the load. Mode 1 sends 10 bits, with no ninth bit.
- R4: In modes 2 and 3, an 11-bit frame is sent. The value of `bit9_i` captured at the load is sent between the eighth data bit and the stop bit.
- R5: In mode 2, each bit lasts 64 clock cycles when `dbl_i` was 0 at the load, and 32 clock cycles when it was 1.
- R6: In mode 0, the 8 data bits leave on `txd_o` least significant bit first, 12 clock cycles each, with no start or stop bit. For each bit, `sclk_o` is low during the first 6 cycles and high during the last 6 cycles.
- R7: In the asynchronous modes, `done_o` rises in the same cycle that the stop bit appears on `txd_o`.
- R8: In mode 0, `done_o` rises when the eighth bit time ends, 8×12 cycles after the load was accepted, and not before.
- R9: `done_o` stays high until `flag_clr_i` is sampled high. It is then low from the next cycle on.
- R10: A load strobe sampled while a frame is in progress, including during its stop bit, has no effect on the line. The block becomes free to accept a new load only after the full stop bit has been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load strobe; starts a frame when the block is idle |
| data_i | input | 8 | Byte to send |
| bit9_i | input | 1 | Ninth bit for modes 2 and 3 |
| mode_i | input | 2 | 0 synchronous shift, 1 8-bit UART, 2 9-bit fixed rate, 3 9-bit variable rate |
| dbl_i | input | 1 | Double-rate select for mode 2 |
| baud_tick_i | input | 1 | One-cycle bit-rate pulse for modes 1 and 3 |
| flag_clr_i | input | 1 | Clears the transmit-complete flag |
| txd_o | output | 1 | Serial data line |
| sclk_o | output | 1 | Shift clock for mode 0, idle high |
| done_o | output | 1 | Transmit-complete flag |

## Verification
The assertions assume that `baud_tick_i` is a pulse lasting one cycle. They also assume that a clear and a flag set never fall in the same cycle, because the block gives priority to the set. The bench drives the tick itself, at an exact period counted from the load. It pulses the clear only several cycles after a frame has finished, so it never coincides with a set. Stray loads are driven only in the middle of bits, or in the middle of the stop bit, so they are sampled while a frame is in progress.

// File: rtl/ser9_pkg.sv
package ser9_pkg;

  typedef enum logic [1:0] {
    MODE_SYNC    = 2'd0,
    MODE_ASYNC8  = 2'd1,
    MODE_FIXED9  = 2'd2,
    MODE_VAR9    = 2'd3
  } tx_mode_e;

  function automatic logic mode_async(tx_mode_e m);
    return m != MODE_SYNC;
  endfunction

  function automatic logic mode_ninth(tx_mode_e m);
    return (m == MODE_FIXED9) || (m == MODE_VAR9);
  endfunction

  function automatic logic mode_internal_rate(tx_mode_e m);
    return (m == MODE_SYNC) || (m == MODE_FIXED9);
  endfunction

endpackage

// File: rtl/ser9_rate.sv
module ser9_rate
  import ser9_pkg::*;
#(
  parameter int SYNC_DIV  = 12,
  parameter int FIXED_DIV = 64
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     restart_i,
  input  logic     run_i,
  input  tx_mode_e mode_i,
  input  logic     dbl_i,
  input  logic     ext_tick_i,
  output logic     bit_tick_o,
  output logic     low_half_o
);

  localparam int MAX_DIV = (FIXED_DIV > SYNC_DIV) ? FIXED_DIV : SYNC_DIV;
  localparam int CNT_W   = $clog2(MAX_DIV);

  logic [CNT_W-1:0] cnt_q, cnt_d, period_m1;
  logic             internal;

  always_comb begin
    internal = mode_internal_rate(mode_i);
    if (mode_i == MODE_SYNC)
      period_m1 = CNT_W'(SYNC_DIV - 1);
    else if (dbl_i)
      period_m1 = CNT_W'(FIXED_DIV / 2 - 1);
    else
      period_m1 = CNT_W'(FIXED_DIV - 1);
  end

  always_comb begin
    bit_tick_o = run_i && (internal ? (cnt_q == period_m1) : ext_tick_i);
    low_half_o = cnt_q < CNT_W'(SYNC_DIV / 2);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)
      cnt_d = '0;
    else if (run_i && internal)
      cnt_d = bit_tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> cnt_q == '0);

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && internal) |-> cnt_q <= period_m1);

endmodule

// File: rtl/ser9_frame.sv
module ser9_frame
  import ser9_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bit9_i,
  input  tx_mode_e          mode_i,
  input  logic              dbl_i,
  input  logic              bit_tick_i,
  output logic              busy_o,
  output logic              txd_o,
  output tx_mode_e          cur_mode_o,
  output logic              cur_dbl_o,
  output logic              accept_o,
  output logic              flag_set_o
);

  localparam int FRAME_W = DATA_W + 3;
  localparam int IDX_W   = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sreg_q, sreg_d, load_vec;
  logic [IDX_W-1:0]   idx_q, idx_d, last_idx;
  logic               busy_q, busy_d, dbl_q, dbl_d;
  tx_mode_e           mode_q, mode_d;

  // Frame image for the mode being loaded; bit 0 leaves first.
  always_comb begin
    case (mode_i)
      MODE_SYNC:   load_vec = {3'b111, data_i};
      MODE_ASYNC8: load_vec = {2'b11, data_i, 1'b0};
      default:     load_vec = {1'b1, bit9_i, data_i, 1'b0};
    endcase
  end

  always_comb begin
    case (mode_q)
      MODE_SYNC:   last_idx = IDX_W'(DATA_W - 1);
      MODE_ASYNC8: last_idx = IDX_W'(DATA_W + 1);
      default:     last_idx = IDX_W'(DATA_W + 2);
    endcase
  end

  always_comb begin
    accept_o   = load_i && !busy_q;
    flag_set_o = bit_tick_i &&
                 (mode_async(mode_q) ? (idx_q == last_idx - 1'b1)
                                     : (idx_q == last_idx));
  end

  always_comb begin
    sreg_d = sreg_q;
    idx_d  = idx_q;
    busy_d = busy_q;
    mode_d = mode_q;
    dbl_d  = dbl_q;
    if (accept_o) begin
      sreg_d = load_vec;
      idx_d  = '0;
      busy_d = 1'b1;
      mode_d = mode_i;
      dbl_d  = dbl_i;
    end else if (busy_q && bit_tick_i) begin
      sreg_d = {1'b1, sreg_q[FRAME_W-1:1]};
      if (idx_q == last_idx) begin
        idx_d  = '0;
        busy_d = 1'b0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '1;
      idx_q  <= '0;
      busy_q <= 1'b0;
      mode_q <= MODE_SYNC;
      dbl_q  <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      idx_q  <= idx_d;
      busy_q <= busy_d;
      mode_q <= mode_d;
      dbl_q  <= dbl_d;
    end
  end

  assign txd_o      = sreg_q[0];
  assign busy_o     = busy_q;
  assign cur_mode_o = mode_q;
  assign cur_dbl_o  = dbl_q;

  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> txd_o);

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && mode_async(mode_i)) |=> !txd_o);

  a_r4_ninth_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && mode_ninth(mode_i)) |=> sreg_q[DATA_W+1] == $past(bit9_i));

  a_r7_flag_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set_o && mode_async(mode_q)) |=> (txd_o && busy_q));

  a_r8_flag_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set_o && mode_q == MODE_SYNC) |=> !busy_q);

  a_r10_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && load_i && !bit_tick_i) |=> ($stable(sreg_q) && busy_q));

endmodule

// File: rtl/ser9_flag.sv
module ser9_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic done_o
);

  logic done_q, done_d;

  always_comb begin
    done_d = done_q;
    if (set_i)      done_d = 1'b1;
    else if (clr_i) done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign done_o = done_q;

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr_i) |=> done_q);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !done_q);

endmodule

// File: rtl/ser9_tx.sv
module ser9_tx
  import ser9_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SYNC_DIV  = 12,
  parameter int FIXED_DIV = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bit9_i,
  input  logic [1:0]        mode_i,
  input  logic              dbl_i,
  input  logic              baud_tick_i,
  input  logic              flag_clr_i,
  output logic              txd_o,
  output logic              sclk_o,
  output logic              done_o
);

  logic     busy, accept, flag_set, bit_tick, low_half, cur_dbl;
  tx_mode_e cur_mode;

  ser9_frame #(.DATA_W(DATA_W)) frame_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .data_i     (data_i),
    .bit9_i     (bit9_i),
    .mode_i     (tx_mode_e'(mode_i)),
    .dbl_i      (dbl_i),
    .bit_tick_i (bit_tick),
    .busy_o     (busy),
    .txd_o      (txd_o),
    .cur_mode_o (cur_mode),
    .cur_dbl_o  (cur_dbl),
    .accept_o   (accept),
    .flag_set_o (flag_set)
  );

  ser9_rate #(.SYNC_DIV(SYNC_DIV), .FIXED_DIV(FIXED_DIV)) rate_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_i  (accept),
    .run_i      (busy),
    .mode_i     (cur_mode),
    .dbl_i      (cur_dbl),
    .ext_tick_i (baud_tick_i),
    .bit_tick_o (bit_tick),
    .low_half_o (low_half)
  );

  ser9_flag flag_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .clr_i  (flag_clr_i),
    .done_o (done_o)
  );

  assign sclk_o = !(busy && cur_mode == MODE_SYNC && low_half);

  a_r1_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_o);

  a_r6_sclk_async_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_mode != MODE_SYNC) |-> sclk_o);

endmodule

// File: tb/ser9_tx_tb_top.sv
module ser9_tx_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          mode;
    int          n;
    int          p;
    logic [10:0] bits;
  } frame_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       load_i, bit9_i, dbl_i, baud_tick_i, flag_clr_i;
  logic [7:0] data_i;
  logic [1:0] mode_i;
  logic       txd_o, sclk_o, done_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  frame_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ser9_tx dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .data_i(data_i),
    .bit9_i(bit9_i), .mode_i(mode_i), .dbl_i(dbl_i),
    .baud_tick_i(baud_tick_i), .flag_clr_i(flag_clr_i),
    .txd_o(txd_o), .sclk_o(sclk_o), .done_o(done_o)
  );

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Driver: pushes the expected frame, drives the load, ticks and stray loads.
  task automatic send(input int m, input logic dbl, input logic [7:0] d,
                      input logic b9, input int q, input int stray);
    frame_t it;
    int p;
    bit ext;
    ext = (m == 1) || (m == 3);
    p = (m == 0) ? 12 : (m == 2) ? (dbl ? 32 : 64) : q;
    it.mode = m;
    it.p = p;
    if (m == 0)      begin it.n = 8;  it.bits = {3'b111, d}; end
    else if (m == 1) begin it.n = 10; it.bits = {2'b11, d, 1'b0}; end
    else             begin it.n = 11; it.bits = {1'b1, b9, d, 1'b0}; end
    @(negedge clk);
    sb_q.push_back(it);
    load_i = 1'b1; data_i = d; bit9_i = b9; mode_i = m[1:0]; dbl_i = dbl;
    for (int k = 0; k < it.n; k++) begin
      for (int j = 1; j <= p; j++) begin
        @(negedge clk);
        load_i = (k == stray) && (j == p / 2);
        if (load_i) begin data_i = ~d; bit9_i = ~b9; end
        baud_tick_i = ext && (j == p);
      end
    end
    @(negedge clk);
    baud_tick_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", "flag held", done_o, 1'b1);
    if (stray >= 0) check("R10", "no frame from stray load", txd_o, 1'b1);
    flag_clr_i = 1'b1;
    @(negedge clk);
    flag_clr_i = 1'b0;
    check("R9", "flag cleared", done_o, 1'b0);
  endtask

  // Monitor: pops the expected frame at the accepted load and samples each bit.
  task automatic watch(input frame_t it);
    int e = 0;
    int m;
    for (int k = 0; k <= it.n; k++) begin
      for (int s = 1; s <= 3; s++) begin
        if (k == it.n) begin
          if (s > 1) break;
          m = it.n * it.p + 2;
        end else begin
          m = k * it.p + (s * it.p) / 4;
        end
        repeat (m - e) @(posedge clk);
        e = m;
        @(negedge clk);
        if (k == it.n) begin
          check("R1", "line idle after frame", txd_o, 1'b1);
          check("R1", "sclk idle after frame", sclk_o, 1'b1);
          check(it.mode == 0 ? "R8" : "R7", "flag after frame", done_o, 1'b1);
        end else if (s == 2) begin
          check(it.mode == 0 ? "R6" : (it.mode == 1 ? "R3" :
                (k == 9 ? "R4" : (it.mode == 2 ? "R5" : "R2"))),
                $sformatf("bit %0d", k), txd_o, it.bits[k]);
          if (it.mode == 0) check("R8", "flag low during bits", done_o, 1'b0);
          else check("R7", $sformatf("flag at bit %0d", k), done_o, k == it.n - 1);
        end else begin
          check("R6", "shift clock phase", sclk_o,
                (it.mode == 0 && s == 1) ? 1'b0 : 1'b1);
        end
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (load_i === 1'b1 && sb_q.size() != 0) watch(sb_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; load_i = 1'b0; data_i = '0; bit9_i = 1'b0; mode_i = '0;
    dbl_i = 1'b0; baud_tick_i = 1'b0; flag_clr_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "reset txd", txd_o, 1'b1);
    check("R1", "reset sclk", sclk_o, 1'b1);
    check("R1", "reset flag", done_o, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    send(1, 1'b0, 8'hA5, 1'b1, 8, -1);   // R3 8-bit frame on ticks
    send(3, 1'b0, 8'h3C, 1'b1, 8, -1);   // R4 ninth bit one
    send(3, 1'b1, 8'hC6, 1'b0, 6, -1);   // R4 ninth bit zero, other tick period
    send(2, 1'b0, 8'h81, 1'b1, 0, -1);   // R5 64 cycles per bit
    send(2, 1'b1, 8'h5A, 1'b0, 0, 3);    // R5 32 cycles, R10 stray load mid frame
    send(2, 1'b1, 8'h96, 1'b1, 0, 10);   // R10 stray load in stop bit
    send(0, 1'b0, 8'hC3, 1'b0, 0, -1);   // R6 R8 synchronous mode
    send(0, 1'b0, 8'h01, 1'b0, 0, 2);    // R6 R10 stray in synchronous mode
    send(1, 1'b0, 8'hFF, 1'b0, 5, -1);   // R2 all ones
    repeat (5) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule